// File: doc/BRIEF.md
# Card Detect Latch Register

This block is a small register file that sits beside a removable storage card slot. Software reaches it over a word-addressed 32-bit register bus and finds four words: a fixed identification value, a placeholder for a flash programming function that is not present (reads zero, ignores writes), a slot status word, and a fixed decode value.

The status word combines two indications from the slot. The write-protect indication is shown live: it follows its input after synchronisation. The card-insertion indication is sticky: a high level on the insert input sets a flag that remains set after the input drops, and that flag drives the interrupt output. Software acknowledges an insertion by writing the status word with the insert bit set (write-one-to-clear). Both slot inputs are asynchronous and pass through a configurable flop chain before use.

Reads are combinational from the word address; a write takes effect at the clock edge on which the write strobe is high.

Top module: `card_detect_regs`

## Requirements
- R1: Word 0 reads the identification constant 0x41034003.
- R2: Word 1 reads zero, and a write to it changes no readable state.
- R3: Word 3 reads the constant 0x11, and a write to it changes no readable state.
- R4: Bit 0 of the status word (word 2) shows the write-protect input level, delayed by the synchroniser depth (two clock edges with the default of two stages).
- R5: A high level on the card-insert input sets bit 3 of the status word three clock edges later (two synchroniser edges plus the latch edge), and the bit stays 1 after the input returns low.
- R6: A write to word 2 with bit 3 of the write data equal to 1 clears the insert bit at that clock edge; a write to word 2 with bit 3 equal to 0 leaves it unchanged whatever the other data bits are.
- R7: When the synchronised insert level is high on the same edge as a clearing write, the insert bit stays 1.
- R8: The interrupt output always equals bit 3 of the status word.
- R9: After reset the status word reads zero and the interrupt output is low; status bits other than 0 and 3 always read zero.
- R10: When the address is wider than two bits, any word index above 3 reads zero and a write to it has no effect, including on the insert bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Word address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| wp_in | input | 1 | Write-protect indication from the slot (asynchronous) |
| ins_in | input | 1 | Card-insert indication from the slot (asynchronous) |
| irq_out | output | 1 | Card insertion interrupt |

## Verification
The bench builds the block with a four-bit word address and the default two-stage synchroniser. The wider address puts word indices 4 to 15 in reach, so the bench can show that a write to an alias of the status word (index 6) neither clears the insert flag nor reads back anything but zero, while the two-stage depth fixes the exact edge on which write-protect and insert changes appear. The clear-versus-set collision is produced by holding the insert input high through a clearing write.

// File: rtl/cdl_pkg.sv
package cdl_pkg;

   // Word indices of the register file; software depends on this order.
   typedef enum logic [1:0] {
      CDL_W_ID   = 2'd0,
      CDL_W_PROG = 2'd1,
      CDL_W_STAT = 2'd2,
      CDL_W_DEC  = 2'd3
   } cdl_word_e;

   // Status word bit positions.
   localparam int unsigned CDL_WP_BIT  = 0;
   localparam int unsigned CDL_INS_BIT = 3;

   // Fixed read values.
   localparam logic [31:0] CDL_ID_CONST  = 32'h4103_4003;
   localparam logic [31:0] CDL_DEC_CONST = 32'h0000_0011;

endpackage

// File: rtl/cdl_sync.sv
module cdl_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("cdl_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/cdl_status.sv
module cdl_status
   import cdl_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_s,
   input  logic              ins_s,
   input  logic              clr_req,
   output logic [DATA_W-1:0] status,
   output logic              ins_flag
);

   generate
      if (DATA_W <= CDL_INS_BIT) begin : g_bad_width
         $error("cdl_status: DATA_W too narrow for status bits");
      end
   endgenerate

   logic ins_q;

   // Set has priority over a software clear on the same edge.
   always_ff @(posedge clk) begin
      if (!rst_n)       ins_q <= 1'b0;
      else if (ins_s)   ins_q <= 1'b1;
      else if (clr_req) ins_q <= 1'b0;
   end

   always_comb begin
      status              = '0;
      status[CDL_WP_BIT]  = wp_s;
      status[CDL_INS_BIT] = ins_q;
   end

   assign ins_flag = ins_q;

   // R5
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_flag && !clr_req) |=> ins_flag);

   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_s |=> ins_flag);

   // R6
   clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !ins_s) |=> !ins_flag);

   // R9
   spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(status) <= 2);

endmodule

// File: rtl/cdl_regbus.sv
module cdl_regbus
   import cdl_pkg::*;
#(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned DATA_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] status,
   output logic [DATA_W-1:0] rdata,
   output logic              clr_req
);

   localparam int unsigned ID_W = (DATA_W < 32) ? DATA_W : 32;

   cdl_word_e word;
   logic      in_range;
   logic      unused_wdata_bits;

   assign word = cdl_word_e'(addr[1:0]);

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("cdl_regbus: ADDR_W must be at least 2");
      end
      if (ADDR_W > 2) begin : g_wide
         assign in_range = ~|addr[ADDR_W-1:2];
      end else begin : g_exact
         assign in_range = 1'b1;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (in_range) begin
         unique case (word)
            CDL_W_ID:   rdata[ID_W-1:0] = CDL_ID_CONST[ID_W-1:0];
            CDL_W_PROG: rdata = '0;
            CDL_W_STAT: rdata = status;
            CDL_W_DEC:  rdata[ID_W-1:0] = CDL_DEC_CONST[ID_W-1:0];
            default:    rdata = '0;
         endcase
      end
   end

   assign clr_req = wr & in_range & (word == CDL_W_STAT) & wdata[CDL_INS_BIT];

   assign unused_wdata_bits = ^{wdata[DATA_W-1:CDL_INS_BIT+1], wdata[CDL_INS_BIT-1:0]};

endmodule

// File: rtl/card_detect_regs.sv
module card_detect_regs
   import cdl_pkg::*;
#(
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              wp_in,
   input  logic              ins_in,
   output logic              irq_out
);

   logic              wp_s;
   logic              ins_s;
   logic              clr_req;
   logic              ins_flag;
   logic [DATA_W-1:0] status;
   logic              addr_is_stat;

   cdl_sync #(.STAGES(SYNC_STAGES)) u_wp_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (wp_in),
      .q_sync  (wp_s)
   );

   cdl_sync #(.STAGES(SYNC_STAGES)) u_ins_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (ins_in),
      .q_sync  (ins_s)
   );

   cdl_status #(.DATA_W(DATA_W)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .wp_s     (wp_s),
      .ins_s    (ins_s),
      .clr_req  (clr_req),
      .status   (status),
      .ins_flag (ins_flag)
   );

   cdl_regbus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regbus (
      .addr    (reg_addr),
      .wr      (reg_wr),
      .wdata   (reg_wdata),
      .status  (status),
      .rdata   (reg_rdata),
      .clr_req (clr_req)
   );

   assign irq_out      = ins_flag;
   assign addr_is_stat = (reg_addr == ADDR_W'(CDL_W_STAT));

   // R8
   irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_is_stat |-> (irq_out == reg_rdata[CDL_INS_BIT]));

   // R4
   wp_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_is_stat |-> (reg_rdata[CDL_WP_BIT] == wp_s));

   // R2
   prog_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(CDL_W_PROG)) |-> (reg_rdata == '0));

   // R10
   alias_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !addr_is_stat && irq_out) |=> irq_out);

endmodule

// File: tb/sim_card_detect_regs.sv
`timescale 1ns/1ps
module sim_card_detect_regs;

   localparam int unsigned AW = 4;
   localparam int unsigned DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic          reg_wr = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          wp_in = 1'b0;
   logic          ins_in = 1'b0;
   logic          irq_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   card_detect_regs #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .wp_in     (wp_in),
      .ins_in    (ins_in),
      .irq_out   (irq_out)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input int a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = AW'(a);
      #1 v = reg_rdata;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_addr  = AW'(a);
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(2, v);
      check("R9 status after reset", v, 32'h0);
      check("R9 irq after reset", {31'b0, irq_out}, 32'h0);
   endtask

   task automatic t_const_words;
      logic [31:0] v;
      rd(0, v); check("R1 id word", v, 32'h4103_4003);
      rd(1, v); check("R2 prog word", v, 32'h0);
      rd(3, v); check("R3 decode word", v, 32'h11);
   endtask

   task automatic t_write_protect;
      logic [31:0] v;
      @(negedge clk); reg_addr = AW'(2); wp_in = 1'b1;
      @(negedge clk); #1 check("R4 wp after one edge", {31'b0, reg_rdata[0]}, 32'h0);
      @(negedge clk); #1 check("R4 wp after two edges", reg_rdata, 32'h1);
      wp_in = 1'b0;
      cycles(2);
      rd(2, v); check("R4 wp follows low", v, 32'h0);
   endtask

   task automatic t_insert;
      logic [31:0] v;
      @(negedge clk); reg_addr = AW'(2); ins_in = 1'b1;
      @(negedge clk); @(negedge clk);
      #1 check("R5 insert not yet latched", {31'b0, irq_out}, 32'h0);
      @(negedge clk); #1 check("R5 insert latched", reg_rdata, 32'h8);
      check("R8 irq follows insert", {31'b0, irq_out}, 32'h1);
      ins_in = 1'b0;
      cycles(4);
      rd(2, v); check("R5 insert sticky", v, 32'h8);
   endtask

   task automatic t_ignored_writes;
      logic [31:0] v;
      wr(1, 32'hFFFF_FFFF);
      rd(1, v); check("R2 prog write ignored", v, 32'h0);
      wr(3, 32'hFFFF_FFFF);
      rd(3, v); check("R3 decode write ignored", v, 32'h11);
      rd(2, v); check("R2 R3 insert untouched", v, 32'h8);
      wr(2, 32'hFFFF_FFF7);
      rd(2, v); check("R6 write without bit3 ignored", v, 32'h8);
   endtask

   task automatic t_alias;
      logic [31:0] v;
      rd(6, v); check("R10 alias reads zero", v, 32'h0);
      rd(15, v); check("R10 top index reads zero", v, 32'h0);
      wr(6, 32'h8);
      rd(2, v); check("R10 alias write no clear", v, 32'h8);
   endtask

   task automatic t_clear;
      logic [31:0] v;
      wr(2, 32'h8);
      rd(2, v); check("R6 clear", v, 32'h0);
      check("R8 irq low after clear", {31'b0, irq_out}, 32'h0);
   endtask

   task automatic t_priority;
      logic [31:0] v;
      @(negedge clk); ins_in = 1'b1;
      cycles(3);
      wr(2, 32'h8);
      rd(2, v); check("R7 set wins over clear", v, 32'h8);
      check("R8 irq held", {31'b0, irq_out}, 32'h1);
      ins_in = 1'b0;
      cycles(3);
      wr(2, 32'h8);
      rd(2, v); check("R6 clear after input low", v, 32'h0);
   endtask

   task automatic t_both;
      logic [31:0] v;
      @(negedge clk); wp_in = 1'b1; ins_in = 1'b1;
      cycles(3);
      ins_in = 1'b0;
      cycles(3);
      rd(2, v); check("R9 only bits 0 and 3", v, 32'h9);
   endtask

   initial begin
      cycles(3);
      rst_n = 1'b1;
      t_reset();
      t_const_words();
      t_write_protect();
      t_insert();
      t_ignored_writes();
      t_alias();
      t_clear();
      t_priority();
      t_both();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule